// File: doc/BRIEF.md
# OUT Record Transfer Sequencer

This block sends one byte record of any length to a USB endpoint as a series of OUT packets of up to 64 bytes. The transmit path has two packet buffers. A start command gives the endpoint number, the total byte count and the number of consecutive NAKs that can be tolerated. The sequencer then drives the outside logic: buffer fill commands (record offset and length), count commits that hand a filled buffer to the bus side, rewrites of a buffer's leading byte, and packet launches. It takes back one transfer-done pulse with a 4-bit handshake code for each launch.

Filling a free buffer always comes before waiting on the bus. Once one packet is in flight, the next packet is loaded into the other buffer. For each outstanding packet the block keeps its byte count and first byte: the packet in flight is the current one and the waiting packet is the pending one. When a packet is NAK'd it is re-armed in place. The block commits a count of zero, rewrites the first byte, recommits the count and then launches the packet again.

A record ends with a one-cycle done pulse that carries a result code. The code is 0 on success, 4 when the NAK limit is reached, and otherwise the failing handshake code itself.

Top module: `out_record_seq`

## Requirements
- R1: Fill number k (counting from 0) carries record offset 64*k and length min(64, total - 64*k). The source byte at `src_addr_o` is taken as that packet's first byte.
- R2: At most two packets are loaded and not yet ACKed, so fill k never happens before packet k-2 has been ACKed. The internal free-buffer count stays between 0 and 2.
- R3: When no packet is outstanding, a fill is followed in the next cycles by a commit of its length and then a launch.
- R4: While bytes remain and a buffer is free, loading comes before handling a transfer result. When a transfer-done pulse for packet p arrives, min(p+2, packet total) fills have already been issued.
- R5: Every launch carries the start endpoint number, and it is preceded by a commit of the length of the packet now on the bus. After an ACK the waiting packet is committed and launched.
- R6: On a handshake code of 4 (NAK) below the limit, the outputs are a commit of 0, then a first-byte rewrite equal to the record byte at the packet's offset, then a commit of the packet length, then a launch.
- R7: The NAK count is consecutive and is cleared by an ACK (code 0). When it reaches the limit, the record ends with result 4 and issues no further launch.
- R8: Any handshake code other than 0 or 4 ends the record at once, with that code as the result and no further launch.
- R9: When every packet is ACKed and no bytes remain, `done_o` pulses with result 0 and `busy_o` is low in the same cycle.
- R10: A total of zero gives a done pulse with result 0 and no fill, commit or launch.
- R11: A handshake code is acted upon only after its transfer-done pulse. The done indication is cleared at every launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a record (taken when idle) |
| start_ep_i | input | 4 | Endpoint number |
| start_total_i | input | 16 | Total record bytes |
| start_limit_i | input | 16 | Consecutive NAK limit |
| src_addr_o | output | 16 | Record offset of the next packet's first byte |
| src_byte_i | input | 8 | Record byte at `src_addr_o` |
| fill_o | output | 1 | Fill a free buffer |
| fill_addr_o | output | 16 | Record offset of the fill |
| fill_len_o | output | 7 | Bytes in the fill |
| commit_o | output | 1 | Commit a byte count |
| commit_cnt_o | output | 7 | Committed byte count |
| refirst_o | output | 1 | Rewrite the buffer's first byte |
| refirst_byte_o | output | 8 | Byte to rewrite |
| launch_o | output | 1 | Launch an OUT packet |
| launch_ep_o | output | 4 | Endpoint of the launch |
| xfer_done_i | input | 1 | Transfer-done pulse |
| hrsl_i | input | 4 | Handshake code, valid with the done pulse |
| busy_o | output | 1 | Record in progress |
| done_o | output | 1 | Record finished (one cycle) |
| result_o | output | 4 | Result code, valid with `done_o` |

## Verification
The bench goes after record lengths on and around the 64-byte boundaries (1, 64, 65, 128, 129), a zero-length record, NAK runs that stop one short of the limit and NAK runs that hit it, and error codes that arrive while a second packet is waiting. A design that loaded a third buffer, or waited before loading, would break the fill-count check at each done pulse. A design that forgot to re-arm would skip the zero commit or rewrite the wrong first byte. A NAK counter that was not cleared on ACK would stop too early with result 4. After an ACK, promoting the wrong pair would commit the wrong length before the next launch.

// File: rtl/ors_pkg.sv
package ors_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_RD, S_ARM, S_LAUNCH, S_WAIT, S_ZERO, S_REFB
  } ors_state_t;
  localparam logic [3:0] HR_ACK = 4'h0;
  localparam logic [3:0] HR_NAK = 4'h4;
  localparam logic [3:0] RES_OK = 4'h0;
  localparam logic [3:0] RES_NAKLIM = 4'h4;
endpackage

// File: rtl/ors_chunker.sv
module ors_chunker #(
  parameter int CW  = 16,
  parameter int PKT = 64,
  parameter int LW  = $clog2(PKT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] total_i,
  input  logic          take_i,
  output logic [CW-1:0] rem_o,
  output logic [CW-1:0] addr_o,
  output logic [LW-1:0] len_o
);
  localparam logic [CW-1:0] PKT_C = CW'(PKT);

  assign len_o = (rem_o >= PKT_C) ? LW'(PKT) : rem_o[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_o  <= '0;
      addr_o <= '0;
    end else if (load_i) begin
      rem_o  <= total_i;
      addr_o <= '0;
    end else if (take_i) begin
      rem_o  <= rem_o - CW'(len_o);
      addr_o <= addr_o + PKT_C;
    end
  end
endmodule

// File: rtl/ors_nak_ctr.sv
module ors_nak_ctr #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [NW-1:0] limit_i,
  output logic          hit_o
);
  logic [NW-1:0] cnt_q;

  assign hit_o = (cnt_q + NW'(1)) == limit_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + NW'(1);
  end
endmodule

// File: rtl/ors_slots.sv
module ors_slots #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_i,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic [7:0]    fb_i,
  input  logic          ack_i,
  output logic [1:0]    avail_o,
  output logic [LW-1:0] cur_len_o,
  output logic [7:0]    cur_fb_o
);
  logic [LW-1:0] pend_len_q;
  logic [7:0]    pend_fb_q;

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      avail_o    <= 2'd2;
      cur_len_o  <= '0;
      cur_fb_o   <= '0;
      pend_len_q <= '0;
      pend_fb_q  <= '0;
    end else if (load_i) begin
      avail_o <= avail_o - 2'd1;
      if (avail_o == 2'd2) begin
        cur_len_o <= len_i;
        cur_fb_o  <= fb_i;
      end else begin
        pend_len_q <= len_i;
        pend_fb_q  <= fb_i;
      end
    end else if (ack_i) begin
      avail_o   <= avail_o + 2'd1;
      cur_len_o <= pend_len_q;
      cur_fb_o  <= pend_fb_q;
    end
  end
endmodule

// File: rtl/out_record_seq.sv
module out_record_seq
  import ors_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PKT = 64,
  parameter int LW  = $clog2(PKT + 1),
  parameter int NW  = 16,
  parameter int EPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [EPW-1:0] start_ep_i,
  input  logic [CW-1:0]  start_total_i,
  input  logic [NW-1:0]  start_limit_i,
  output logic [CW-1:0]  src_addr_o,
  input  logic [7:0]     src_byte_i,
  output logic           fill_o,
  output logic [CW-1:0]  fill_addr_o,
  output logic [LW-1:0]  fill_len_o,
  output logic           commit_o,
  output logic [LW-1:0]  commit_cnt_o,
  output logic           refirst_o,
  output logic [7:0]     refirst_byte_o,
  output logic           launch_o,
  output logic [EPW-1:0] launch_ep_o,
  input  logic           xfer_done_i,
  input  logic [3:0]     hrsl_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [3:0]     result_o
);
  ors_state_t     state_q;
  logic [EPW-1:0] ep_q;
  logic [NW-1:0]  limit_q;
  logic           dflag_q;
  logic [3:0]     res_q;
  logic [CW-1:0]  rem_w;
  logic [LW-1:0]  len_w;
  logic [1:0]     avail_w;
  logic [LW-1:0]  cur_len_w;
  logic [7:0]     cur_fb_w;
  logic           hit_w;

  logic start_ev, take_ev, eval_ev, ack_ev, nak_ev;
  assign start_ev = (state_q == S_IDLE) && start_i;
  assign take_ev  = (state_q == S_RD);
  assign eval_ev  = (state_q == S_WAIT) && dflag_q;
  assign ack_ev   = eval_ev && (res_q == HR_ACK);
  assign nak_ev   = eval_ev && (res_q == HR_NAK);

  ors_chunker #(.CW(CW), .PKT(PKT), .LW(LW)) u_chunk (
    .clk(clk), .rst(rst), .load_i(start_ev), .total_i(start_total_i),
    .take_i(take_ev), .rem_o(rem_w), .addr_o(src_addr_o), .len_o(len_w)
  );

  ors_nak_ctr #(.NW(NW)) u_nak (
    .clk(clk), .rst(rst), .clr_i(start_ev || ack_ev), .inc_i(nak_ev),
    .limit_i(limit_q), .hit_o(hit_w)
  );

  ors_slots #(.LW(LW)) u_slots (
    .clk(clk), .rst(rst), .init_i(start_ev), .load_i(take_ev),
    .len_i(len_w), .fb_i(src_byte_i), .ack_i(ack_ev),
    .avail_o(avail_w), .cur_len_o(cur_len_w), .cur_fb_o(cur_fb_w)
  );

  // Done indication: set by the transfer-done pulse, cleared at launch or use
  always_ff @(posedge clk) begin
    if (rst) begin
      dflag_q <= 1'b0;
      res_q   <= '0;
    end else if (state_q == S_LAUNCH || eval_ev) begin
      dflag_q <= 1'b0;
    end else if (xfer_done_i) begin
      dflag_q <= 1'b1;
      res_q   <= hrsl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= S_IDLE;
      ep_q           <= '0;
      limit_q        <= '0;
      fill_o         <= 1'b0;
      fill_addr_o    <= '0;
      fill_len_o     <= '0;
      commit_o       <= 1'b0;
      commit_cnt_o   <= '0;
      refirst_o      <= 1'b0;
      refirst_byte_o <= '0;
      launch_o       <= 1'b0;
      launch_ep_o    <= '0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      result_o       <= '0;
    end else begin
      fill_o    <= 1'b0;
      commit_o  <= 1'b0;
      refirst_o <= 1'b0;
      launch_o  <= 1'b0;
      done_o    <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          ep_q    <= start_ep_i;
          limit_q <= start_limit_i;
          if (start_total_i == '0) begin
            done_o   <= 1'b1;
            result_o <= RES_OK;
          end else begin
            busy_o  <= 1'b1;
            state_q <= S_PICK;
          end
        end
        S_PICK: begin
          if (rem_w != '0 && avail_w != 2'd0) begin
            state_q <= S_RD;
          end else if (avail_w == 2'd2) begin
            done_o   <= 1'b1;
            result_o <= RES_OK;
            busy_o   <= 1'b0;
            state_q  <= S_IDLE;
          end else begin
            state_q <= S_WAIT;
          end
        end
        S_RD: begin
          fill_o      <= 1'b1;
          fill_addr_o <= src_addr_o;
          fill_len_o  <= len_w;
          state_q     <= (avail_w == 2'd2) ? S_ARM : S_PICK;
        end
        S_ARM: begin
          commit_o     <= 1'b1;
          commit_cnt_o <= cur_len_w;
          state_q      <= S_LAUNCH;
        end
        S_LAUNCH: begin
          launch_o    <= 1'b1;
          launch_ep_o <= ep_q;
          state_q     <= S_PICK;
        end
        S_WAIT: if (dflag_q) begin
          if (res_q == HR_ACK) begin
            state_q <= (avail_w == 2'd0) ? S_ARM : S_PICK;
          end else if (res_q == HR_NAK && !hit_w) begin
            state_q <= S_ZERO;
          end else begin
            done_o   <= 1'b1;
            result_o <= (res_q == HR_NAK) ? RES_NAKLIM : res_q;
            busy_o   <= 1'b0;
            state_q  <= S_IDLE;
          end
        end
        S_ZERO: begin
          commit_o     <= 1'b1;
          commit_cnt_o <= '0;
          state_q      <= S_REFB;
        end
        S_REFB: begin
          refirst_o      <= 1'b1;
          refirst_byte_o <= cur_fb_w;
          state_q        <= S_ARM;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ors_checker.sv
module ors_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          fill_o,
  input logic          commit_o,
  input logic [LW-1:0] commit_cnt_o,
  input logic          refirst_o,
  input logic          launch_o,
  input logic          done_o,
  input logic          busy_o,
  input logic [1:0]    avail
);
  a_r2_avail_range: assert property (@(posedge clk) disable iff (rst)
    avail <= 2'd2);
  a_r6_zero_then_rewrite: assert property (@(posedge clk) disable iff (rst)
    (commit_o && commit_cnt_o == '0) |=> refirst_o);
  a_r6_rewrite_then_recommit: assert property (@(posedge clk) disable iff (rst)
    refirst_o |=> (commit_o && commit_cnt_o != '0));
  a_r3_commit_then_launch: assert property (@(posedge clk) disable iff (rst)
    (commit_o && commit_cnt_o != '0) |=> launch_o);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  a_r5_launch_in_record: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> busy_o);
  a_r11_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_o, commit_o, refirst_o, launch_o, done_o}));
endmodule

bind out_record_seq ors_checker #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .fill_o(fill_o), .commit_o(commit_o),
  .commit_cnt_o(commit_cnt_o), .refirst_o(refirst_o), .launch_o(launch_o),
  .done_o(done_o), .busy_o(busy_o), .avail(avail_w)
);

// File: tb/out_record_seq_tb.sv
module out_record_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start_i = 1'b0;
  logic [3:0]  start_ep_i = '0;
  logic [15:0] start_total_i = '0;
  logic [15:0] start_limit_i = '0;
  logic [15:0] src_addr_o;
  logic [7:0]  src_byte_i;
  logic        fill_o, commit_o, refirst_o, launch_o, busy_o, done_o;
  logic [15:0] fill_addr_o;
  logic [6:0]  fill_len_o, commit_cnt_o;
  logic [7:0]  refirst_byte_o;
  logic [3:0]  launch_ep_o, result_o;
  logic        xfer_done_i = 1'b0;
  logic [3:0]  hrsl_i = '0;

  out_record_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_ep_i(start_ep_i),
    .start_total_i(start_total_i), .start_limit_i(start_limit_i),
    .src_addr_o(src_addr_o), .src_byte_i(src_byte_i), .fill_o(fill_o),
    .fill_addr_o(fill_addr_o), .fill_len_o(fill_len_o), .commit_o(commit_o),
    .commit_cnt_o(commit_cnt_o), .refirst_o(refirst_o),
    .refirst_byte_o(refirst_byte_o), .launch_o(launch_o),
    .launch_ep_o(launch_ep_o), .xfer_done_i(xfer_done_i), .hrsl_i(hrsl_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [7:0] memb(input int a);
    return 8'((a * 13) + (a >> 6) * 7 + 5);
  endfunction
  always_comb src_byte_i = memb(int'(src_addr_o));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // case description
  int total_c, limit_c, err_at_c, err_code_c, npk;
  int nakrun[16];
  logic [3:0] ep_c;
  int exp_res, exp_launch, exp_stop;

  function automatic int lenof(input int p);
    int r = total_c - 64 * p;
    return (r >= 64) ? 64 : r;
  endfunction

  task automatic compute_expect();
    int j = 0;
    bit stop = 0;
    exp_res = 0; exp_stop = npk;
    for (int p = 0; p < npk && !stop; p++) begin
      for (int k = 0; !stop; k++) begin
        if (j == err_at_c) begin
          exp_res = err_code_c; j++; exp_stop = p; stop = 1;
        end else if (k < nakrun[p]) begin
          j++;
          if (k + 1 == limit_c) begin exp_res = 4; exp_stop = p; stop = 1; end
        end else begin
          j++; break;
        end
      end
    end
    exp_launch = j;
  endtask

  // monitor and peripheral model
  int fills, pkt, nakc, launches, last_commit, cnt_dn, cyc, fill_cyc;
  bit active, case_done;
  logic [3:0] resp;

  always @(negedge clk) begin
    cyc++;
    xfer_done_i <= 1'b0;
    if (!rst) begin
      if (fill_o) begin
        chk(int'(fill_addr_o) == 64 * fills, "R1 fill offset", int'(fill_addr_o), 64 * fills);
        chk(int'(fill_len_o) == lenof(fills), "R1 fill length", int'(fill_len_o), lenof(fills));
        chk(fills <= pkt + 1, "R2 fill ahead of two buffers", fills, pkt + 1);
        fills++; fill_cyc = cyc;
      end
      if (commit_o) last_commit = int'(commit_cnt_o);
      if (refirst_o)
        chk(refirst_byte_o == memb(64 * pkt), "R6 first byte rewrite",
            int'(refirst_byte_o), int'(memb(64 * pkt)));
      if (launch_o) begin
        chk(active, "R8 launch after record end", 0, 1);
        chk(last_commit == lenof(pkt), "R5 commit before launch", last_commit, lenof(pkt));
        chk(launch_ep_o == ep_c, "R5 launch endpoint", int'(launch_ep_o), int'(ep_c));
        if (launches == 0)
          chk(cyc - fill_cyc == 2, "R3 fill-commit-launch spacing", cyc - fill_cyc, 2);
        if (launches == err_at_c) resp = 4'(err_code_c);
        else if (nakc < nakrun[pkt]) begin resp = 4'h4; nakc++; end
        else resp = 4'h0;
        launches++;
        cnt_dn = 6 + int'($urandom_range(0, 10));
      end else if (cnt_dn > 0) begin
        cnt_dn--;
        if (cnt_dn == 0) begin
          chk(fills == ((pkt + 2 < npk) ? pkt + 2 : npk), "R4 load before result",
              fills, (pkt + 2 < npk) ? pkt + 2 : npk);
          xfer_done_i <= 1'b1;
          hrsl_i <= resp;
          if (resp == 4'h0) begin pkt++; nakc = 0; end
        end
      end
      if (done_o) begin
        active = 0; case_done = 1;
        chk(result_o == 4'(exp_res), "R9 R7 R8 result code", int'(result_o), exp_res);
        chk(launches == exp_launch, "R7 R8 launch total", launches, exp_launch);
        chk(fills == ((exp_stop + 2 < npk) ? exp_stop + 2 : npk), "R2 fill total",
            fills, (exp_stop + 2 < npk) ? exp_stop + 2 : npk);
        chk(!busy_o, "R9 busy low at done", int'(busy_o), 0);
      end
    end
  end

  task automatic run_case(input int tot, input int lim, input int ea, input int ec);
    int wd = 0;
    total_c = tot; limit_c = lim; err_at_c = ea; err_code_c = ec;
    npk = (tot + 63) / 64;
    ep_c = 4'($urandom_range(0, 15));
    compute_expect();
    fills = 0; pkt = 0; nakc = 0; launches = 0; last_commit = -1; cnt_dn = 0;
    case_done = 0; active = 1;
    @(negedge clk);
    start_i = 1'b1; start_ep_i = ep_c; start_total_i = 16'(tot); start_limit_i = 16'(lim);
    @(negedge clk);
    start_i = 1'b0;
    while (!case_done && wd < 20000) begin @(negedge clk); wd++; end
    if (!case_done) begin
      chk(0, "R9 watchdog, record never finished", wd, 0);
      rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_naks();
    for (int i = 0; i < 16; i++) nakrun[i] = 0;
  endtask

  initial begin
    int ec_tab[4] = '{1, 5, 6, 14};
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !launch_o && !fill_o, "R9 reset state", int'(busy_o), 0);
    clear_naks();
    run_case(0, 3, -1, 0);      // R10 empty record
    chk(fills == 0 && launches == 0, "R10 no activity for zero total", fills + launches, 0);
    run_case(1, 3, -1, 0);
    run_case(64, 3, -1, 0);
    run_case(65, 3, -1, 0);
    run_case(128, 3, -1, 0);
    run_case(512, 3, -1, 0);
    nakrun[0] = 2; nakrun[1] = 2; nakrun[2] = 2;
    run_case(129, 3, -1, 0);    // R7 NAKs below limit on each packet
    clear_naks(); nakrun[1] = 3;
    run_case(200, 3, -1, 0);    // R7 limit reached on packet 1
    clear_naks(); nakrun[0] = 1;
    run_case(100, 1, -1, 0);    // R7 limit of one
    clear_naks();
    run_case(300, 3, 2, 14);    // R8 error while a packet waits
    run_case(30, 3, 0, 5);      // R8 error on first launch
    for (int t = 0; t < 14; t++) begin
      for (int i = 0; i < 16; i++) nakrun[i] = int'($urandom_range(0, 2));
      run_case(int'($urandom_range(1, 1024)), int'($urandom_range(1, 4)),
               ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 10)) : -1,
               ec_tab[$urandom_range(0, 3)]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 global watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule